// File: doc/BRIEF.md
# Serial Control Word Frame Generator

This block sits on the host side of a three-wire control link. When asked to start, it takes a control word of `WORD_W` bits (11 by default) and sends it as one frame of serial clock, serial data and latch waveforms. A receiving shift register takes data on serial clock rising edges while latch is low, and copies its contents to its outputs on the latch rising edge. The first bit on the wire (D1) is `word_i[0]`, and the last is `word_i[WORD_W-1]`.

The serial clock is a gated burst made by binary division of the fast reference clock `clk`. A half serial period is `2**DIV_LOG2` reference cycles at the fast rate, and twice that at the slow rate. With a fast reference and a suitable `DIV_LOG2`, the two rates give 500 kHz and 250 kHz. Latch goes low one half period before the first rising clock edge. Data changes only when the clock falls. After the last rising edge, latch goes high while the clock is still high, and the clock falls one half period later. The burst then stops, the bit counter clears and the block returns to idle. A frame takes 2·`WORD_W`+1 half periods.

Top module: `ctlw_frame_gen`

## Requirements
- R1: While reset is asserted and after it is released, `latch_o` is 1 and `sclk_o`, `sdata_o` and `busy_o` are 0.
- R2: One frame sends every bit of the word captured at start, `word_i[0]` first. A receiver that shifts on `sclk_o` rising edges while `latch_o` is low, and captures on the `latch_o` rising edge, ends up holding exactly that word.
- R3: Each frame has exactly `WORD_W` rising edges on `sclk_o`.
- R4: `sdata_o` changes only in the cycle where `sclk_o` or `latch_o` falls. It never changes while `sclk_o` is high or on a rising clock edge, and it is stable for at least one half period before each rising edge.
- R5: `latch_o` falls exactly one half period before the first rising edge of `sclk_o`.
- R6: `latch_o` rises only while `sclk_o` is high, after the last rising edge. `sclk_o` falls exactly one half period after that.
- R7: A half period is `2**DIV_LOG2` reference cycles when `rate_sel_i`=0, and `2**(DIV_LOG2+1)` when `rate_sel_i`=1. `busy_o` stays high for (2·`WORD_W`+1) half periods.
- R8: A `start_i` that is high while `busy_o` is high is ignored. The frame in flight keeps its word and its timing.
- R9: `word_i` and `rate_sel_i` are sampled only in the cycle a start is accepted. Changes made during a frame have no effect on that frame.
- R10: `busy_o` rises in the cycle after an accepted start, together with the fall of `latch_o`. While `busy_o` is low, `latch_o` is 1 and `sclk_o` is 0. If `start_i` is held high, the next frame starts after exactly one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send one frame |
| rate_sel_i | input | 1 | 0 = fast serial rate, 1 = half rate |
| word_i | input | WORD_W | Control word; bit 0 is sent first |
| sclk_o | output | 1 | Gated serial clock |
| sdata_o | output | 1 | Serial data |
| latch_o | output | 1 | Latch strobe, low during shifting |
| busy_o | output | 1 | Frame in progress |

## Verification
A start request can arrive in the same cycle as the final half-period tick, which drops the clock and ends the frame. The bench provokes this in two ways. First, it pulses start in the middle of a frame with a different word and the other rate. Second, it holds start high through the end of a frame so that the request meets the final tick and the return to idle. It judges the result from the word captured by a bench-side receiver, from the measured busy length, and from the single idle cycle between back-to-back frames.

// File: rtl/ctlw_pkg.sv
package ctlw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_HIGH,
      ST_LOW,
      ST_HOLD
   } seq_state_t;

   function automatic int unsigned frame_halves(input int unsigned nbits);
      return 2 * nbits + 1;
   endfunction
endpackage

// File: rtl/ctlw_prescaler.sv
module ctlw_prescaler #(
   parameter int unsigned DIV_LOG2 = 2,
   parameter bit          DUAL_RATE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic slow_i,
   output logic tick_o
);
   localparam int unsigned CNT_W = DIV_LOG2 + 1;

   logic [CNT_W-1:0] cnt_q;
   logic             tick_fast;
   logic             tick_slow;

   initial begin
      assert (DIV_LOG2 >= 1) else $error("DIV_LOG2 must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_fast = &cnt_q[DIV_LOG2-1:0];
   assign tick_slow = &cnt_q;

   generate
      if (DUAL_RATE) begin : g_dual
         assign tick_o = slow_i ? tick_slow : tick_fast;
      end else begin : g_single
         logic unused_slow;
         assign unused_slow = slow_i;
         assign tick_o = tick_fast;
      end
   endgenerate

   // R7
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o && !clear_i |=> !tick_o);
endmodule

// File: rtl/ctlw_shifter.sv
module ctlw_shifter #(
   parameter int unsigned WORD_W    = 11,
   parameter bit          D1_AT_LSB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              sdata_o
);
   logic [WORD_W-1:0] sr_q;
   logic [WORD_W-1:0] sr_next;

   initial begin
      assert (WORD_W >= 2) else $error("WORD_W must be at least 2");
   end

   generate
      if (D1_AT_LSB) begin : g_lsb
         assign sr_next = {1'b0, sr_q[WORD_W-1:1]};
         assign sdata_o = sr_q[0];
      end else begin : g_msb
         assign sr_next = {sr_q[WORD_W-2:0], 1'b0};
         assign sdata_o = sr_q[WORD_W-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load_i) begin
         sr_q <= word_i;
      end else if (shift_i) begin
         sr_q <= sr_next;
      end
   end

   // R9
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i && !shift_i |=> $stable(sdata_o));
endmodule

// File: rtl/ctlw_sequencer.sv
module ctlw_sequencer
   import ctlw_pkg::*;
#(
   parameter int unsigned WORD_W = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic tick_i,
   output logic go_o,
   output logic shift_o,
   output logic sclk_o,
   output logic latch_o,
   output logic busy_o
);
   localparam int unsigned BC_W = $clog2(WORD_W);
   localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

   seq_state_t       state_q;
   logic [BC_W-1:0]  bitcnt_q;
   logic             sclk_q;
   logic             latch_q;
   logic             at_last;

   assign at_last = (bitcnt_q == LAST_BIT);
   assign go_o    = (state_q == ST_IDLE) && start_i;
   assign shift_o = tick_i && (state_q == ST_HIGH) && !at_last;
   assign sclk_o  = sclk_q;
   assign latch_o = latch_q;
   assign busy_o  = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bitcnt_q <= '0;
         sclk_q   <= 1'b0;
         latch_q  <= 1'b1;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q  <= ST_SETUP;
                  latch_q  <= 1'b0;
                  bitcnt_q <= '0;
               end
            end
            ST_SETUP: begin
               if (tick_i) begin
                  state_q <= ST_HIGH;
                  sclk_q  <= 1'b1;
               end
            end
            ST_HIGH: begin
               if (tick_i) begin
                  if (at_last) begin
                     state_q <= ST_HOLD;
                     latch_q <= 1'b1;
                  end else begin
                     state_q  <= ST_LOW;
                     sclk_q   <= 1'b0;
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end
               end
            end
            ST_LOW: begin
               if (tick_i) begin
                  state_q <= ST_HIGH;
                  sclk_q  <= 1'b1;
               end
            end
            ST_HOLD: begin
               if (tick_i) begin
                  state_q  <= ST_IDLE;
                  sclk_q   <= 1'b0;
                  bitcnt_q <= '0;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R6
   latch_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_q) |-> sclk_q);

   // R10
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> latch_q && !sclk_q);

   // R3
   bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt_q <= LAST_BIT);

   // R10
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $fell(latch_q));
endmodule

// File: rtl/ctlw_frame_gen.sv
module ctlw_frame_gen #(
   parameter int unsigned WORD_W    = 11,
   parameter int unsigned DIV_LOG2  = 2,
   parameter bit          DUAL_RATE = 1'b1,
   parameter bit          D1_AT_LSB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rate_sel_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              sclk_o,
   output logic              sdata_o,
   output logic              latch_o,
   output logic              busy_o
);
   logic go;
   logic shift;
   logic tick;
   logic slow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slow_q <= 1'b0;
      end else if (go) begin
         slow_q <= rate_sel_i;
      end
   end

   ctlw_prescaler #(
      .DIV_LOG2 (DIV_LOG2),
      .DUAL_RATE(DUAL_RATE)
   ) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(go),
      .slow_i (slow_q),
      .tick_o (tick)
   );

   ctlw_sequencer #(
      .WORD_W(WORD_W)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_i),
      .tick_i (tick),
      .go_o   (go),
      .shift_o(shift),
      .sclk_o (sclk_o),
      .latch_o(latch_o),
      .busy_o (busy_o)
   );

   ctlw_shifter #(
      .WORD_W   (WORD_W),
      .D1_AT_LSB(D1_AT_LSB)
   ) u_shf (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (go),
      .shift_i(shift),
      .word_i (word_i),
      .sdata_o(sdata_o)
   );

   // R4
   data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdata_o) |-> ($fell(sclk_o) || $fell(latch_o)));

   // R8
   rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(slow_q));
endmodule

// File: tb/tb_ctlw_frame_gen.sv
module tb_ctlw_frame_gen;
   localparam int W = 11;
   localparam int DL = 2;
   localparam int NH = 2 * W + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic rate = 1'b0;
   logic [W-1:0] word = '0;
   logic sclk, sdata, latch, busy;

   always #2.5 clk = ~clk;

   ctlw_frame_gen #(.WORD_W(W), .DIV_LOG2(DL)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .rate_sel_i(rate),
      .word_i(word), .sclk_o(sclk), .sdata_o(sdata), .latch_o(latch),
      .busy_o(busy)
   );

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   // bench-side receiver and monitor, sampled on falling clk
   logic p_sclk = 1'b0, p_sdata = 1'b0, p_latch = 1'b1;
   logic [W-1:0] rx_sr = '0, rx_word = '0;
   int rises = 0, chg_bad = 0, setup_bad = 0, since_chg = 0;
   int lat_low = 0, first_gap = 0, lat_rise_hi = 0, lat_to_fall = 0;
   int busy_len = 0, half_cur = 4;
   logic in_tail = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!p_latch && latch) begin
            rx_word = rx_sr;
            lat_rise_hi = sclk ? 1 : 0;
            lat_to_fall = 0;
            in_tail = 1'b1;
         end
         if (p_latch && !latch) begin
            rises = 0; chg_bad = 0; setup_bad = 0; lat_low = 0; busy_len = 0;
         end
         if (sclk && !p_sclk) begin
            if (!latch) begin
               if (rises == 0) first_gap = lat_low;
               rx_sr = {sdata, rx_sr[W-1:1]};
               rises = rises + 1;
               if (since_chg < half_cur) setup_bad = setup_bad + 1;
            end
            if (sdata != p_sdata) chg_bad = chg_bad + 1;
         end
         if (p_sclk && sclk && sdata != p_sdata) chg_bad = chg_bad + 1;
         if (in_tail) begin
            if (!sclk) in_tail = 1'b0;
            else lat_to_fall = lat_to_fall + 1;
         end
         if (sdata != p_sdata) since_chg = 1; else since_chg = since_chg + 1;
         if (!latch) lat_low = lat_low + 1;
         if (busy) busy_len = busy_len + 1;
      end
      p_sclk = sclk; p_sdata = sdata; p_latch = latch;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 5000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic judge(input logic [W-1:0] w, input int half);
      chk(rx_word == w, "R2 word", int'(rx_word), int'(w));
      chk(rises == W, "R3 rises", rises, W);
      chk(chg_bad == 0 && setup_bad == 0, "R4 data timing", chg_bad + setup_bad, 0);
      chk(first_gap == half, "R5 latch lead", first_gap, half);
      chk(lat_rise_hi == 1 && lat_to_fall == half, "R6 latch tail", lat_to_fall, half);
      chk(busy_len == NH * half, "R7 busy length", busy_len, NH * half);
   endtask

   // disturb=1 drives a new start, word and rate mid-frame (R8, R9)
   task automatic send(input logic [W-1:0] w, input bit r, input bit disturb);
      int half;
      half = r ? (2 << DL) : (1 << DL);
      @(negedge clk);
      half_cur = half;
      word = w; rate = r; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1 && latch == 1'b0, "R10 busy with latch fall", int'(busy), 1);
      if (disturb) begin
         repeat (3 * half) @(negedge clk);
         word = ~w; rate = ~r; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (half) @(negedge clk);
         word = w ^ 11'h2A5;
      end
      wait_idle();
      @(negedge clk);
      judge(w, half);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 190000) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(latch && !sclk && !sdata && !busy, "R1 in reset", {latch, sclk, sdata, busy}, 4'b1000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1 after release
      chk(latch && !sclk && !sdata && !busy, "R1 after reset", {latch, sclk, sdata, busy}, 4'b1000);

      send(11'h000, 1'b0, 1'b0);
      send(11'h7FF, 1'b0, 1'b0);
      send(11'h555, 1'b1, 1'b0);
      send(11'h2AA, 1'b1, 1'b0);
      for (int v = 1; v < W; v++) send(11'(1 << v), 1'b0, 1'b0);
      for (int v = 0; v < 2048; v += 13) send(11'(v), 1'b0, 1'b0);
      for (int v = 5; v < 2048; v += 61) send(11'(v), 1'b1, 1'b0);

      // R8 and R9: start, word and rate disturbed mid-frame
      send(11'h3C9, 1'b0, 1'b1);
      send(11'h146, 1'b1, 1'b1);

      // R10: start held high across frame end, one idle cycle between frames
      @(negedge clk);
      half_cur = 1 << DL;
      word = 11'h5B3; rate = 1'b0; start = 1'b1;
      @(negedge clk);
      wait_idle();
      chk(busy == 1'b0 && latch && !sclk, "R10 idle levels", int'(busy), 0);
      @(negedge clk);
      chk(busy == 1'b1, "R10 back-to-back restart", int'(busy), 1);
      chk(rx_word == 11'h5B3, "R2 first back-to-back word", int'(rx_word), 'h5B3);
      start = 1'b0;
      wait_idle();
      @(negedge clk);
      judge(11'h5B3, 1 << DL);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule